// File: doc/BRIEF.md
# I2C Quick-Command Bus Master

This block runs a zero-length I2C transfer, the probe that SMBus calls a quick command. It drives the clock and data lines directly through open-drain enables, one state per bus phase. The phases are: a wait for an idle bus, a START, one address byte made of a 7-bit target address and a direction bit, an acknowledge slot, and a STOP. The reply comes back as one of four result flags. Each flag stays set until the next request begins.

Every delay comes from a two-row table chosen by a mode input: standard-rate timing or fast-rate timing. Each delay is given in nanoseconds and converted to a clock-cycle count from the clock-frequency parameter, rounding up. Wherever the master lets SCL rise, it waits until the line actually reads high, so a target that stretches the clock is honoured. Every such wait is bounded by a cycle limit. If the limit runs out, the transfer is abandoned with a stuck-bus result.

Top module: `i2cq_master`

## Requirements
- R1: While reset is high and after it is released, both line enables are low (lines released), and busy, done, ack, nack, stuck and bad_req are all low.
- R2: A request with ten_bit high is refused. done and bad_req rise one clock after the start pulse, and SCL is never pulled low.
- R3: After a start pulse, the master releases both lines and waits until both read high. It then waits at least the bus-free time (standard 4700 ns, fast 1300 ns) before pulling SDA low while SCL is high. SCL first goes low no sooner than the START hold time (standard 4000 ns, fast 600 ns) after that.
- R4: The address byte on the bus is {addr, rd}, most significant bit first, with rd=1 meaning read. SDA changes only while SCL is low.
- R5: Every SCL low period lasts at least the low time (standard 4700 ns, fast 1300 ns). Every SCL high period lasts at least the high time (standard 4000 ns, fast 600 ns). Each nanosecond value becomes ceil(ns * CLK_HZ / 1e9) cycles. The low period is split into two equal halves of ceil(low/2) cycles, and SDA is updated at the midpoint.
- R6: In the ninth clock the master releases SDA and samples it once SCL reads high. Low gives ack, high gives nack.
- R7: The STOP pulls both lines low for the low time, then releases SCL. Once SCL reads high, the master waits at least the STOP setup time (standard 4000 ns, fast 600 ns) and releases SDA. It then waits the bus-free time and reports done, with both lines left released.
- R8: When a target holds SCL low after release, the master waits. The high time is counted from the moment SCL reads high.
- R9: If any wait for a line to read high lasts STUCK_CYC cycles, the master releases both lines and raises done and stuck. This applies to the idle-bus wait, each clock rise, and the STOP rise.
- R10: done is a one-cycle pulse, and exactly one of ack, nack, stuck, bad_req is set with it. The flags keep their value until the next accepted start pulse, which clears them.
- R11: A start pulse while busy is ignored. The transfer in progress keeps its address, direction and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request pulse |
| fast | input | 1 | 1 selects fast-rate timing, 0 standard |
| addr | input | AW | 7-bit target address |
| rd | input | 1 | Direction bit placed after the address |
| ten_bit | input | 1 | Request uses 10-bit addressing (refused) |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ack | output | 1 | Target acknowledged the address |
| nack | output | 1 | Target did not acknowledge |
| stuck | output | 1 | A line failed to rise within the limit |
| bad_req | output | 1 | Request refused (10-bit address) |

## Verification
The bound checker covers the protocol around the result on every cycle. It checks that done lasts one cycle and carries exactly one flag, that the flags stay fixed while idle, that an idle master pulls neither line, and that a refusal comes straight after the request. The bench covers what is visible only on the bus, using a target model on the wired lines. That includes the bit order of the address byte, the measured length of each low and high period in both modes, the START hold, STOP setup and bus-free gaps, acknowledge sampling, clock stretching just short of and beyond the limit, and lines held low before the transfer starts.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  // bus phase timings, nanoseconds
  localparam int STD_BUF_NS  = 4700;
  localparam int STD_HD_NS   = 4000;
  localparam int STD_LOW_NS  = 4700;
  localparam int STD_HIGH_NS = 4000;
  localparam int STD_SU_NS   = 4000;
  localparam int FST_BUF_NS  = 1300;
  localparam int FST_HD_NS   = 600;
  localparam int FST_LOW_NS  = 1300;
  localparam int FST_HIGH_NS = 600;
  localparam int FST_SU_NS   = 600;

  typedef enum logic [3:0] {
    S_IDLE, S_FREE, S_BUF, S_HOLD, S_LOW_A, S_LOW_B, S_RISE, S_HIGH,
    S_P_LOW, S_P_RISE, S_P_SU, S_P_BUF
  } qstate_t;

  // round a nanosecond delay up to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int hz);
    longint unsigned prod;
    prod = longint'(ns) * longint'(hz);
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/i2cq_timing.sv
module i2cq_timing #(
  parameter int CLK_HZ = 50_000_000,
  parameter int CW     = 16
) (
  input  logic          fast,
  output logic [CW-1:0] t_buf,
  output logic [CW-1:0] t_hd,
  output logic [CW-1:0] t_half,
  output logic [CW-1:0] t_high,
  output logic [CW-1:0] t_su,
  output logic [CW-1:0] t_low
);
  import i2cq_pkg::*;

  localparam int SB = ns_to_cyc(STD_BUF_NS, CLK_HZ);
  localparam int SH = ns_to_cyc(STD_HD_NS, CLK_HZ);
  localparam int SL = ns_to_cyc(STD_LOW_NS, CLK_HZ);
  localparam int SG = ns_to_cyc(STD_HIGH_NS, CLK_HZ);
  localparam int SS = ns_to_cyc(STD_SU_NS, CLK_HZ);
  localparam int FB = ns_to_cyc(FST_BUF_NS, CLK_HZ);
  localparam int FH = ns_to_cyc(FST_HD_NS, CLK_HZ);
  localparam int FL = ns_to_cyc(FST_LOW_NS, CLK_HZ);
  localparam int FG = ns_to_cyc(FST_HIGH_NS, CLK_HZ);
  localparam int FS = ns_to_cyc(FST_SU_NS, CLK_HZ);

  assign t_buf  = fast ? CW'(FB) : CW'(SB);
  assign t_hd   = fast ? CW'(FH) : CW'(SH);
  assign t_low  = fast ? CW'(FL) : CW'(SL);
  assign t_half = fast ? CW'((FL + 1) / 2) : CW'((SL + 1) / 2);
  assign t_high = fast ? CW'(FG) : CW'(SG);
  assign t_su   = fast ? CW'(FS) : CW'(SS);

endmodule

// File: rtl/i2cq_shift.sv
module i2cq_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [BW-1:0] din,
  output logic          bit_o
);
  logic [BW-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= din;
    else if (adv)  sr <= {sr[BW-2:0], 1'b0};
  end

  assign bit_o = sr[BW-1];

endmodule

// File: rtl/i2cq_master.sv
module i2cq_master #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int STUCK_CYC = CLK_HZ / 28,
  parameter int AW        = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fast,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          ten_bit,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          ack,
  output logic          nack,
  output logic          stuck,
  output logic          bad_req
);
  import i2cq_pkg::*;

  localparam int BW      = AW + 1;
  localparam int STD_MAX = ns_to_cyc(STD_BUF_NS, CLK_HZ);
  localparam int CNT_MAX = (STUCK_CYC > STD_MAX) ? STUCK_CYC : STD_MAX;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int NW      = $clog2(BW + 1);

  qstate_t       st;
  logic [CW-1:0] cnt, lim;
  logic [NW-1:0] bitn;
  logic          fast_q, scl_drv, sda_drv, ack_smp;
  logic          tick, fail, last_bit, cur_bit, load_sh, adv_sh;
  logic [CW-1:0] t_buf, t_hd, t_half, t_high, t_su, t_low;

  i2cq_timing #(.CLK_HZ(CLK_HZ), .CW(CW)) u_tim (
    .fast(fast_q), .t_buf(t_buf), .t_hd(t_hd), .t_half(t_half),
    .t_high(t_high), .t_su(t_su), .t_low(t_low)
  );

  i2cq_shift #(.BW(BW)) u_sh (
    .clk(clk), .rst(rst), .load(load_sh), .adv(adv_sh),
    .din({addr, rd}), .bit_o(cur_bit)
  );

  // cycle limit of the current phase; wait phases use the stuck limit
  always_comb begin
    unique case (st)
      S_BUF, S_P_BUF:  lim = t_buf;
      S_HOLD:          lim = t_hd;
      S_LOW_A, S_LOW_B: lim = t_half;
      S_HIGH:          lim = t_high;
      S_P_LOW:         lim = t_low;
      S_P_SU:          lim = t_su;
      default:         lim = CW'(STUCK_CYC);
    endcase
  end

  assign tick     = (cnt == lim - 1'b1);
  assign last_bit = (bitn == NW'(BW));
  assign fail     = tick && (((st == S_FREE) && !(scl_in && sda_in)) ||
                             (((st == S_RISE) || (st == S_P_RISE)) && !scl_in));
  assign load_sh  = (st == S_IDLE) && start && !ten_bit;
  assign adv_sh   = (st == S_HIGH) && tick && !last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      fast_q  <= 1'b0;
      scl_drv <= 1'b0;
      sda_drv <= 1'b0;
      ack_smp <= 1'b0;
      done    <= 1'b0;
      ack     <= 1'b0;
      nack    <= 1'b0;
      stuck   <= 1'b0;
      bad_req <= 1'b0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt + 1'b1;
      if (fail) begin
        st      <= S_IDLE;
        scl_drv <= 1'b0;
        sda_drv <= 1'b0;
        stuck   <= 1'b1;
        done    <= 1'b1;
      end else begin
        unique case (st)
          S_IDLE: begin
            cnt <= '0;
            if (start) begin
              {ack, nack, stuck, bad_req} <= '0;
              if (ten_bit) begin
                bad_req <= 1'b1;
                done    <= 1'b1;
              end else begin
                fast_q <= fast;
                st     <= S_FREE;
              end
            end
          end
          S_FREE: if (scl_in && sda_in) begin st <= S_BUF; cnt <= '0; end
          S_BUF: if (tick) begin
            sda_drv <= 1'b1;
            st <= S_HOLD; cnt <= '0;
          end
          S_HOLD: if (tick) begin
            scl_drv <= 1'b1;
            bitn <= '0;
            st <= S_LOW_A; cnt <= '0;
          end
          S_LOW_A: if (tick) begin
            sda_drv <= last_bit ? 1'b0 : !cur_bit;
            st <= S_LOW_B; cnt <= '0;
          end
          S_LOW_B: if (tick) begin
            scl_drv <= 1'b0;
            st <= S_RISE; cnt <= '0;
          end
          S_RISE: if (scl_in) begin
            if (last_bit) ack_smp <= !sda_in;
            st <= S_HIGH; cnt <= '0;
          end
          S_HIGH: if (tick) begin
            scl_drv <= 1'b1;
            cnt <= '0;
            if (last_bit) begin
              sda_drv <= 1'b1;
              st <= S_P_LOW;
            end else begin
              bitn <= bitn + 1'b1;
              st <= S_LOW_A;
            end
          end
          S_P_LOW: if (tick) begin
            scl_drv <= 1'b0;
            st <= S_P_RISE; cnt <= '0;
          end
          S_P_RISE: if (scl_in) begin st <= S_P_SU; cnt <= '0; end
          S_P_SU: if (tick) begin
            sda_drv <= 1'b0;
            st <= S_P_BUF; cnt <= '0;
          end
          S_P_BUF: if (tick) begin
            done <= 1'b1;
            ack  <= ack_smp;
            nack <= !ack_smp;
            st <= S_IDLE; cnt <= '0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign scl_oe = scl_drv;
  assign sda_oe = sda_drv;
  assign busy   = (st != S_IDLE);

endmodule

// File: rtl/i2cq_master_chk.sv
module i2cq_master_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic ack,
  input logic nack,
  input logic stuck,
  input logic bad_req,
  input logic scl_oe,
  input logic sda_oe
);

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe)) else $error("idle master drives a line"); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R10

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones({ack, nack, stuck, bad_req}) == 1)) else $error("result not one-hot"); // R10

  AST_REFUSE_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (done && bad_req) |-> $past(start)) else $error("refusal not immediate"); // R2

  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start)) |-> $stable({ack, nack, stuck, bad_req}))
    else $error("result flags changed while idle"); // R10

endmodule

bind i2cq_master i2cq_master_chk u_chk (.*);

// File: tb/i2cq_master_test.sv
module i2cq_master_test;

  localparam int CLK_HZ = 50_000_000;
  localparam int STUCK  = 3000;
  localparam int SLACK  = 4;

  typedef struct packed {
    logic        fast;
    logic [6:0]  addr;
    logic        rd;
    logic        ten;
    logic        tack;
    logic [12:0] stretch;
    logic        stk_scl;
    logic        stk_sda;
    logic [1:0]  exp;     // 0 ack, 1 nack, 2 stuck, 3 refused
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 7'h50, 1'b0, 1'b0, 1'b1, 13'd0,    1'b0, 1'b0, 2'd0},
    '{1'b1, 7'h2A, 1'b1, 1'b0, 1'b1, 13'd0,    1'b0, 1'b0, 2'd0},
    '{1'b0, 7'h7F, 1'b1, 1'b0, 1'b0, 13'd0,    1'b0, 1'b0, 2'd1},
    '{1'b1, 7'h01, 1'b0, 1'b0, 1'b0, 13'd0,    1'b0, 1'b0, 2'd1},
    '{1'b1, 7'h55, 1'b0, 1'b0, 1'b1, 13'd500,  1'b0, 1'b0, 2'd0},
    '{1'b1, 7'h33, 1'b0, 1'b0, 1'b1, 13'd4000, 1'b0, 1'b0, 2'd2},
    '{1'b0, 7'h10, 1'b0, 1'b1, 1'b1, 13'd0,    1'b0, 1'b0, 2'd3},
    '{1'b1, 7'h44, 1'b0, 1'b0, 1'b1, 13'd0,    1'b1, 1'b0, 2'd2},
    '{1'b0, 7'h44, 1'b1, 1'b0, 1'b1, 13'd0,    1'b0, 1'b1, 2'd2}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, start = 1'b0, fast = 1'b0, rd = 1'b0, ten_bit = 1'b0;
  logic [6:0] addr = '0;
  logic       scl_in, sda_in, scl_oe, sda_oe, busy, done, ack, nack, stuck, bad_req;

  // target model state
  logic tack = 1'b0, stk_scl = 1'b0, stk_sda = 1'b0, hflag = 1'b0, tgt_sda_low = 1'b0;
  int   hcnt = 0, stretch = 0;

  assign scl_in = !(scl_oe || hflag || stk_scl);
  assign sda_in = !(sda_oe || tgt_sda_low || stk_sda);

  i2cq_master #(.CLK_HZ(CLK_HZ), .STUCK_CYC(STUCK), .AW(7)) uut (
    .clk(clk), .rst(rst), .start(start), .fast(fast), .addr(addr), .rd(rd),
    .ten_bit(ten_bit), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(busy), .done(done), .ack(ack), .nack(nack),
    .stuck(stuck), .bad_req(bad_req)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cy(input int ns);
    longint p;
    p = longint'(ns) * CLK_HZ;
    return int'((p + 999_999_999) / 1_000_000_000);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bus monitor
  logic pv_scl = 1'b1, pv_sda = 1'b1, in_txn = 1'b0, stop_seen = 1'b0;
  int   start_t = -1, last_fall = -1, last_rise = -1, hold_t = -1, su_t = -1;
  int   min_low = 1_000_000, min_high = 1_000_000, falls = 0, nbits = 0;
  logic [7:0] cap = '0;

  always @(negedge clk) begin
    logic s_scl, s_sda;
    s_scl = scl_in;
    s_sda = sda_in;
    if (pv_scl && s_scl && pv_sda && !s_sda) begin
      in_txn = 1'b1; start_t = cyc; last_fall = -1; last_rise = -1; hold_t = -1;
    end else if (pv_scl && s_scl && !pv_sda && s_sda && in_txn) begin
      in_txn = 1'b0; stop_seen = 1'b1; su_t = cyc - last_rise;
    end
    if (pv_scl && !s_scl) begin
      falls++;
      if (in_txn) begin
        if (last_fall < 0) hold_t = cyc - start_t;
        else if (last_rise >= 0 && (cyc - last_rise) < min_high) min_high = cyc - last_rise;
        last_fall = cyc;
        if (nbits == 8) begin
          tgt_sda_low = tack;
          if (stretch > 0) begin hflag = 1'b1; hcnt = stretch; end
        end else if (nbits == 9) tgt_sda_low = 1'b0;
      end
    end
    if (!pv_scl && s_scl && in_txn) begin
      if (last_fall >= 0 && (cyc - last_fall) < min_low) min_low = cyc - last_fall;
      last_rise = cyc;
      if (nbits < 8) cap = {cap[6:0], s_sda};
      nbits++;
    end
    if (hflag && !scl_oe) begin
      if (hcnt == 0) hflag = 1'b0;
      else hcnt--;
    end
    pv_scl = s_scl;
    pv_sda = s_sda;
  end

  task automatic prep(input vec_t v);
    @(negedge clk);
    tack = v.tack; stretch = int'(v.stretch); stk_scl = v.stk_scl; stk_sda = v.stk_sda;
    hflag = 1'b0; hcnt = 0; tgt_sda_low = 1'b0; nbits = 0; cap = '0; falls = 0;
    in_txn = 1'b0; stop_seen = 1'b0; start_t = -1; hold_t = -1; su_t = -1;
    last_fall = -1; last_rise = -1; min_low = 1_000_000; min_high = 1_000_000;
  endtask

  task automatic launch(input vec_t v, output int t0);
    @(negedge clk);
    fast = v.fast; addr = v.addr; rd = v.rd; ten_bit = v.ten; start = 1'b1;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 30000 && !done; k++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int t0, el;
    int tb, th, tl, tg, ts;
    logic [3:0] expf;
    tb = v.fast ? cy(1300) : cy(4700);
    th = v.fast ? cy(600)  : cy(4000);
    tl = v.fast ? cy(1300) : cy(4700);
    tg = v.fast ? cy(600)  : cy(4000);
    ts = v.fast ? cy(600)  : cy(4000);
    prep(v);
    launch(v, t0);
    wait_done();
    el = cyc - t0;
    expf = 4'b1000 >> v.exp;
    chk(done === 1'b1, "R10", "done pulse seen", done, 1);
    chk({ack, nack, stuck, bad_req} === expf, "R6 R9 R2 R10", "result flags",
        {ack, nack, stuck, bad_req}, expf);
    if (v.exp <= 2'd1) begin
      chk(cap === {v.addr, v.rd}, "R4", "address byte", cap, {v.addr, v.rd});
      chk((start_t - t0) >= tb && (start_t - t0) <= tb + SLACK, "R3", "bus free gap", start_t - t0, tb);
      chk(hold_t >= th && hold_t <= th + SLACK, "R3", "start hold", hold_t, th);
      chk(min_low >= tl && min_low <= tl + SLACK, "R5", "min SCL low", min_low, tl);
      chk(min_high >= tg && min_high <= tg + SLACK, v.stretch != 0 ? "R8" : "R5", "min SCL high", min_high, tg);
      chk(stop_seen && su_t >= ts && su_t <= ts + SLACK, "R7", "stop setup", su_t, ts);
      chk(!scl_oe && !sda_oe && !busy, "R7", "lines released at end", {scl_oe, sda_oe, busy}, 0);
    end else if (v.exp == 2'd2) begin
      chk(el >= STUCK, "R9", "cycles before stuck", el, STUCK);
      chk(!scl_oe && !sda_oe, "R9", "lines released after stuck", {scl_oe, sda_oe}, 0);
    end else begin
      chk(el == 1, "R2", "refusal latency", el, 1);
      chk(falls == 0, "R2", "SCL falls on refusal", falls, 0);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190_000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190_000);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int t0;
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, busy, done, ack, nack, stuck, bad_req} === 8'b0, "R1",
        "outputs in reset", {scl_oe, sda_oe, busy, done, ack, nack, stuck, bad_req}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, busy, done, ack, nack, stuck, bad_req} === 8'b0, "R1",
        "outputs after reset", {scl_oe, sda_oe, busy, done, ack, nack, stuck, bad_req}, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i]);
      repeat (20) @(negedge clk);
    end

    // R11: second request during a transfer is ignored
    v = '{1'b1, 7'h3C, 1'b0, 1'b0, 1'b1, 13'd0, 1'b0, 1'b0, 2'd0};
    prep(v);
    launch(v, t0);
    repeat (200) @(negedge clk);
    fast = 1'b0; addr = 7'h11; rd = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(cap === 8'h78, "R11", "byte kept under busy start", cap, 8'h78);
    chk(ack === 1'b1, "R11", "ack kept under busy start", ack, 1);
    chk(min_high <= cy(600) + SLACK, "R11", "fast mode kept", min_high, cy(600));
    repeat (20) @(negedge clk);
    chk(!done && !busy, "R10", "done low after pulse", {done, busy}, 0);
    chk(ack === 1'b1, "R10", "ack held while idle", ack, 1);

    // R10: next accepted start clears old flags
    v = '{1'b0, 7'h10, 1'b0, 1'b1, 1'b1, 13'd0, 1'b0, 1'b0, 2'd3};
    prep(v);
    launch(v, t0);
    chk({ack, bad_req} === 2'b01, "R10", "flags replaced by next request", {ack, bad_req}, 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule